// File: doc/BRIEF.md
# Odd-Step Sequence Counter

This block is a 3-bit synchronous counter with a Moore output. On each enabled rising clock edge its state moves through the fixed cycle 0, 1, 3, 5, 7 and then back to 0, repeating without end. The output is the state register itself, so it depends only on the present state and changes only at clock edges. The state is stored in three toggle-type storage bits. Combinational logic derives each bit's toggle input from the present state.

The three codes that are not part of the cycle (2, 4 and 6) are treated as corrupt. A combinational flag marks them. Each of them returns to 0 on the next enabled edge, so the counter recovers by itself from any upset. A test-only load port writes any code into the state. This lets the recovery path be exercised directly from the block's ports.

Top module: `seq_odd_counter`

## Requirements
- R1: With `en_i` high and `load_i` low, `count_o` steps on each rising edge 0→1→3→5→7→0. The 3-bit value of `count_o` is the unsigned decimal count.
- R2: With `en_i` high and `load_i` low, any of the codes 2, 4 or 6 on `count_o` becomes 0 after the next rising edge.
- R3: With `en_i` low and `load_i` low, `count_o` keeps its value across rising edges. This holds for legal and illegal codes alike.
- R4: While `rst_ni` is low, `count_o` is 0 at once, without waiting for a clock edge. Reset overrides `load_i` and `en_i`.
- R5: `illegal_o` is 1 exactly when `count_o` is 2, 4 or 6, and is 0 for 0, 1, 3, 5 and 7.
- R6: With `load_i` high at a rising edge, `count_o` takes the value of `load_val_i` whatever the level of `en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| load_i | input | 1 | Test-only load strobe |
| load_val_i | input | 3 | Test-only value loaded into the state |
| count_o | output | 3 | Moore output, equal to the state |
| illegal_o | output | 1 | High while the state is an unused code |

## Verification
On every clock cycle, the assertions check the step from each legal value to its successor, the return of unused codes to zero, holding while disabled, the load path and the illegal flag. The bench sweeps all eight codes, each with the enable both low and high, and computes the expected next value arithmetically. Only the bench's scenarios can show that reset acts without a clock edge and wins over a pending load. They also show that a long enabled run stays on the five-value cycle.

// File: rtl/seq_cnt_pkg.sv
package seq_cnt_pkg;
  localparam int unsigned CntW = 3;
  typedef logic [CntW-1:0] cnt_t;

  // required successor; unused codes go to zero
  function automatic cnt_t succ(input cnt_t s);
    case (s)
      3'd0:    succ = 3'd1;
      3'd1:    succ = 3'd3;
      3'd3:    succ = 3'd5;
      3'd5:    succ = 3'd7;
      default: succ = 3'd0;
    endcase
  endfunction

  function automatic logic is_unused(input cnt_t s);
    is_unused = (s == 3'd2) || (s == 3'd4) || (s == 3'd6);
  endfunction
endpackage

// File: rtl/seq_cnt_toggle.sv
module seq_cnt_toggle
  import seq_cnt_pkg::*;
(
  input  cnt_t state_i,
  input  logic en_i,
  output cnt_t tog_o,
  output logic illegal_o
);
  cnt_t nxt;
  assign nxt = succ(state_i);

  for (genvar i = 0; i < CntW; i++) begin : g_tog
    // toggle where present and next differ
    assign tog_o[i] = en_i & (state_i[i] ^ nxt[i]);
  end

  assign illegal_o = is_unused(state_i);
endmodule

// File: rtl/seq_cnt_tff.sv
module seq_cnt_tff #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] tog_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (load_i)   bit_q <= load_val_i[i];
      else if (tog_i[i]) bit_q <= ~bit_q;
    end
    assign q_o[i] = bit_q;
  end
endmodule

// File: rtl/seq_odd_counter.sv
module seq_odd_counter
  import seq_cnt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       load_i,
  input  logic [2:0] load_val_i,
  output logic [2:0] count_o,
  output logic       illegal_o
);
  cnt_t state_q;
  cnt_t tog;

  seq_cnt_toggle i_toggle (
    .state_i  (state_q),
    .en_i     (en_i),
    .tog_o    (tog),
    .illegal_o(illegal_o)
  );

  seq_cnt_tff #(.W(CntW)) i_tff (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .load_val_i(load_val_i),
    .tog_i     (tog),
    .q_o       (state_q)
  );

  assign count_o = state_q;

  assert_step_0_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i && count_o == 3'd0 |=> count_o == 3'd1);
  assert_step_1_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i && count_o == 3'd1 |=> count_o == 3'd3);
  assert_step_3_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i && count_o == 3'd3 |=> count_o == 3'd5);
  assert_step_5_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i && count_o == 3'd5 |=> count_o == 3'd7);
  assert_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i && count_o == 3'd7 |=> count_o == 3'd0);
  assert_recover_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i && illegal_o |=> count_o == 3'd0);
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !load_i |=> $stable(count_o));
  assert_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o == (count_o[0] == 1'b0 && count_o != 3'd0));
  assert_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(load_val_i));
endmodule

// File: tb/test_seq_odd_counter.sv
module test_seq_odd_counter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       load_i = 1'b0;
  logic [2:0] load_val_i = 3'd0;
  logic [2:0] count_o;
  logic       illegal_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  seq_odd_counter i_seq_odd_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .load_i(load_i),
    .load_val_i(load_val_i), .count_o(count_o), .illegal_o(illegal_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int exp_next(input int v);
    if (v == 7) return 0;
    if (v == 0) return 1;
    if (v % 2 == 1) return v + 2;
    return 0;
  endfunction

  function automatic int exp_flag(input int v);
    return (v % 2 == 0 && v != 0) ? 1 : 0;
  endfunction

  // one rising edge; inputs change and outputs are sampled at falling edges
  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #50000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    @(negedge clk_i);
    check("R4 reset value", count_o, 0);
    check("R5 flag in reset", illegal_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 long enabled run
    en_i = 1'b1;
    v = 0;
    for (int k = 0; k < 20; k++) begin
      tick();
      v = exp_next(v);
      check("R1 sequence", count_o, v);
    end

    // R2 R3 R5 R6 sweep of all codes with enable low and high
    for (int code = 0; code < 8; code++) begin
      for (int e = 0; e < 2; e++) begin
        load_i = 1'b1;
        load_val_i = 3'(code);
        en_i = (e == 0);   // R6 load must win over either enable level
        tick();
        load_i = 1'b0;
        check("R6 load", count_o, code);
        check("R5 illegal flag", illegal_o, exp_flag(code));
        en_i = e[0];
        tick();
        if (e == 0) check("R3 hold", count_o, code);
        else if (exp_flag(code) == 1) check("R2 recover", count_o, 0);
        else check("R1 step", count_o, exp_next(code));
        check("R5 flag after edge", illegal_o,
              exp_flag(e == 0 ? code : exp_next(code)));
      end
    end

    // R4 asynchronous reset mid-clock over a pending load
    load_i = 1'b1;
    load_val_i = 3'd5;
    en_i = 1'b1;
    tick();
    check("R6 load before reset", count_o, 5);
    load_val_i = 3'd7;
    #3;
    rst_ni = 1'b0;
    #1;
    check("R4 async reset", count_o, 0);
    tick();
    check("R4 reset beats load", count_o, 0);
    load_i = 1'b0;
    rst_ni = 1'b1;
    tick();
    check("R1 first step after reset", count_o, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule